// File: doc/BRIEF.md
# Dual-Mode Serial Transmit Engine

This block turns bytes written by software into a serial stream on a data pin. It runs in one of three ways: as an asynchronous line with start and stop framing, as a synchronous master that also drives the shift clock, or as a synchronous slave that shifts on a clock supplied from outside. Software writes one control byte and a transmit holding register. A baud tick input from an external rate divider sets the pace of each bit. A frame carries eight data bits, or nine when the extended-frame bit is set. In that case the ninth bit comes from a control bit, and the transmitter does not interpret it.

A byte waits in the holding register until the shift register is empty. It then moves into the shifter one cycle later. This frees the holding register so that software can queue the next byte while the current one is still going out. In synchronous operation, an active receive enable takes priority over transmission. Loading, shifting and output drive all stop while it is asserted.

Top module: `usart_tx_engine`

## Requirements
- R1: After reset the control byte reads 8'h02 (all writable bits 0, shifter-empty bit 1), hold_empty is 1, dout is 1, and ck_oe and ck_out are 0.
- R2: Control byte fields, bit 7 down to bit 0: clock-master select, nine-bit frames, transmit enable, synchronous mode, a bit that always reads 0, fast bit rate, shifter-empty status (read-only), ninth data bit. A write updates every field except bits 3 and 1.
- R3: hold_empty falls the cycle after hold_wr. When the shifter is empty, the holding register is full and transmission is allowed, the shifter loads on the next edge. From the cycle after that edge, status bit 1 reads 0 and hold_empty reads 1.
- R4: An asynchronous frame is one low start bit, then the data bits least significant first, then one high stop bit. dout is high whenever the shifter is empty.
- R5: With nine-bit frames, the ninth data bit is taken from control bit 0 at load time and sent after bit 7. Otherwise eight data bits are sent.
- R6: In asynchronous mode each bit lasts HI_DIV baud ticks (default 16) when the fast-rate bit is 1, and LO_DIV ticks (default 64) when it is 0.
- R7: In synchronous master mode ck_oe is 1 and ck_out idles low. ck_out rises on one baud tick and falls on the next, and dout advances on that fall. There are no start or stop bits.
- R8: In synchronous slave mode ck_oe is 0. dout advances once for each falling edge of ck_in, and the edge is acted on SYNC_STAGES+1 cycles after it appears.
- R9: In synchronous mode with rx_en at 1, no load takes place, shifting and ck_out are frozen, and dout_oe is 0.
- R10: Status bit 1 returns to 1 in the cycle after the edge that ends the last bit of a frame.
- R11: The fast-rate bit has no effect in synchronous mode. Clock-master select has no effect in asynchronous mode (ck_oe stays 0 and timing is unchanged).
- R12: With transmit enable at 0, no new frame is loaded, and the holding register stays full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Write strobe for the control byte |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Control byte read value including status |
| hold_wr | input | 1 | Write strobe for the holding register |
| hold_wdata | input | 8 | Byte to transmit |
| hold_empty | output | 1 | Holding register may be written |
| baud_tick | input | 1 | One-cycle pulse from the rate divider |
| rx_en | input | 1 | Receive function enabled (synchronous priority) |
| dout | output | 1 | Serial data out |
| dout_oe | output | 1 | Drive enable for the data pin |
| ck_in | input | 1 | External shift clock (slave mode) |
| ck_out | output | 1 | Generated shift clock (master mode) |
| ck_oe | output | 1 | Drive enable for the clock pin |

## Verification
A bit counter or tick counter that goes wrong shows up on dout within one bit time. It appears as a start bit or data bit of the wrong length, and the shifter-empty status returns at the wrong cycle. A holding register stuck full or empty is visible on hold_empty in the cycle after the load edge. A wrong mode decode shows on ck_oe and dout_oe straight away, and on ck_out at the next baud tick. The reference model compares every output on every cycle, so a divergence is reported in the cycle it first appears at the pins.

// File: rtl/usart_tx_pkg.sv
package usart_tx_pkg;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = 4;

  typedef struct packed {
    logic clk_master;
    logic nine;
    logic tx_en;
    logic sync;
    logic hi_speed;
    logic bit9;
  } ctl_t;

  // Frame image, first bit at index 0; unused upper slots are idle-high
  function automatic logic [FRAME_W-1:0] build_frame(input logic sync, input logic nine,
                                                     input logic b9, input logic [DATA_W-1:0] d);
    logic top;
    top = nine ? b9 : 1'b1;
    if (sync) return {2'b11, top, d};
    return {1'b1, top, d, 1'b0};
  endfunction

  // Number of bit slots in one frame
  function automatic logic [CNT_W-1:0] frame_len(input logic sync, input logic nine);
    logic [CNT_W-1:0] n;
    n = CNT_W'(DATA_W);
    if (nine) n = n + CNT_W'(1);
    if (!sync) n = n + CNT_W'(2);
    return n;
  endfunction
endpackage

// File: rtl/usart_tx_regs.sv
module usart_tx_regs
  import usart_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [7:0]        ctl_wdata,
  input  logic              hold_wr,
  input  logic [DATA_W-1:0] hold_wdata,
  input  logic              load,
  input  logic              sh_empty,
  output ctl_t              ctl,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_full,
  output logic [7:0]        ctl_rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl       <= '0;
      hold_data <= '0;
      hold_full <= 1'b0;
    end else begin
      if (ctl_wr) begin
        ctl.clk_master <= ctl_wdata[7];
        ctl.nine       <= ctl_wdata[6];
        ctl.tx_en      <= ctl_wdata[5];
        ctl.sync       <= ctl_wdata[4];
        ctl.hi_speed   <= ctl_wdata[2];
        ctl.bit9       <= ctl_wdata[0];
      end
      if (hold_wr) begin
        hold_data <= hold_wdata;
        hold_full <= 1'b1;
      end else if (load) begin
        hold_full <= 1'b0;
      end
    end
  end

  assign ctl_rdata = {ctl.clk_master, ctl.nine, ctl.tx_en, ctl.sync,
                      1'b0, ctl.hi_speed, sh_empty, ctl.bit9};
endmodule

// File: rtl/usart_tx_pace.sv
module usart_tx_pace #(
  parameter int HI_DIV      = 16,
  parameter int LO_DIV      = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic freeze,
  input  logic sync,
  input  logic master,
  input  logic hi_speed,
  input  logic baud_tick,
  input  logic ck_in,
  output logic step,
  output logic ck_out
);
  localparam int MAX_DIV = (LO_DIV > HI_DIV) ? LO_DIV : HI_DIV;
  localparam int DIV_W   = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;
  localparam logic [DIV_W-1:0] HI_LAST = DIV_W'(HI_DIV - 1);
  localparam logic [DIV_W-1:0] LO_LAST = DIV_W'(LO_DIV - 1);

  logic [DIV_W-1:0]       tick_cnt;
  logic                   ck_q;
  logic [SYNC_STAGES-1:0] ck_sync;
  logic                   ck_prev;
  logic                   run, async_step, master_step, slave_step;

  assign run = busy && !freeze;

  // asynchronous bit timer
  assign async_step = !sync && baud_tick && (tick_cnt == (hi_speed ? HI_LAST : LO_LAST));
  always_ff @(posedge clk) begin
    if (!rst_n || !busy) tick_cnt <= '0;
    else if (run && !sync && baud_tick)
      tick_cnt <= async_step ? '0 : tick_cnt + DIV_W'(1);
  end

  // master clock: rise on one tick, fall (and advance) on the next
  assign master_step = sync && master && baud_tick && ck_q;
  always_ff @(posedge clk) begin
    if (!rst_n || !busy) ck_q <= 1'b0;
    else if (run && sync && master && baud_tick) ck_q <= ~ck_q;
  end
  assign ck_out = ck_q;

  // slave clock synchroniser and falling-edge detect
  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) ck_sync <= '0;
        else        ck_sync <= ck_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) ck_sync <= '0;
        else        ck_sync <= {ck_sync[SYNC_STAGES-2:0], ck_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) ck_prev <= 1'b0;
    else        ck_prev <= ck_sync[SYNC_STAGES-1];
  end
  assign slave_step = sync && !master && ck_prev && !ck_sync[SYNC_STAGES-1];

  assign step = run && (async_step || master_step || slave_step);
endmodule

// File: rtl/usart_tx_shift.sv
module usart_tx_shift
  import usart_tx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [CNT_W-1:0]   len_in,
  output logic               dout_bit,
  output logic               empty
);
  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]   left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh   <= '1;
      left <= '0;
    end else if (load) begin
      sh   <= frame_in;
      left <= len_in;
    end else if (step) begin
      sh   <= {1'b1, sh[FRAME_W-1:1]};
      left <= left - CNT_W'(1);
    end
  end

  assign empty    = (left == '0);
  assign dout_bit = empty ? 1'b1 : sh[0];
endmodule

// File: rtl/usart_tx_engine.sv
module usart_tx_engine
  import usart_tx_pkg::*;
#(
  parameter int HI_DIV      = 16,
  parameter int LO_DIV      = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  input  logic       hold_wr,
  input  logic [7:0] hold_wdata,
  output logic       hold_empty,
  input  logic       baud_tick,
  input  logic       rx_en,
  output logic       dout,
  output logic       dout_oe,
  input  logic       ck_in,
  output logic       ck_out,
  output logic       ck_oe
);
  ctl_t              ctl;
  logic [DATA_W-1:0] hold_data;
  logic              hold_full;
  logic              sh_empty;
  logic              load_evt;
  logic              step_evt;
  logic              sync_mode;
  logic              freeze;
  logic              tx_allowed;

  assign sync_mode  = ctl.sync;
  assign freeze     = sync_mode && rx_en;
  assign tx_allowed = ctl.tx_en && !freeze;
  assign load_evt   = sh_empty && hold_full && tx_allowed;

  usart_tx_regs u_regs (
    .clk, .rst_n, .ctl_wr, .ctl_wdata, .hold_wr, .hold_wdata,
    .load(load_evt), .sh_empty, .ctl, .hold_data, .hold_full, .ctl_rdata
  );

  usart_tx_pace #(.HI_DIV(HI_DIV), .LO_DIV(LO_DIV), .SYNC_STAGES(SYNC_STAGES)) u_pace (
    .clk, .rst_n, .busy(!sh_empty), .freeze, .sync(sync_mode),
    .master(ctl.clk_master), .hi_speed(ctl.hi_speed), .baud_tick, .ck_in,
    .step(step_evt), .ck_out
  );

  usart_tx_shift u_shift (
    .clk, .rst_n, .load(load_evt), .step(step_evt),
    .frame_in(build_frame(sync_mode, ctl.nine, ctl.bit9, hold_data)),
    .len_in(frame_len(sync_mode, ctl.nine)),
    .dout_bit(dout), .empty(sh_empty)
  );

  assign hold_empty = !hold_full;
  assign dout_oe    = tx_allowed;
  assign ck_oe      = sync_mode && ctl.clk_master;
endmodule

// File: rtl/usart_tx_engine_chk.sv
module usart_tx_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic load_evt,
  input logic step_evt,
  input logic sh_empty,
  input logic hold_empty,
  input logic hold_wr,
  input logic dout,
  input logic dout_oe,
  input logic ck_out,
  input logic ck_oe,
  input logic sync_mode,
  input logic rx_en
);
  AST_LOAD_TAKES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt && !hold_wr |=> !sh_empty && hold_empty); // R3
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt && !sync_mode |=> !dout); // R4
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sh_empty |-> dout); // R4
  AST_CK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    sh_empty |-> !ck_out); // R7
  AST_RX_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    sync_mode && rx_en |-> !load_evt && !step_evt && !dout_oe); // R9
  AST_EMPTY_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sh_empty) |-> $past(step_evt)); // R10
  AST_ASYNC_NO_CK: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_mode |-> !ck_oe); // R11
endmodule

bind usart_tx_engine usart_tx_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .load_evt(load_evt), .step_evt(step_evt),
  .sh_empty(sh_empty), .hold_empty(hold_empty), .hold_wr(hold_wr),
  .dout(dout), .dout_oe(dout_oe), .ck_out(ck_out), .ck_oe(ck_oe),
  .sync_mode(sync_mode), .rx_en(rx_en)
);

// File: tb/sim_usart_tx_engine.sv
`timescale 1ns/1ps
module sim_usart_tx_engine;
  localparam int HI = 16, LO = 64, SS = 2;

  logic clk = 0, rst_n = 0;
  logic ctl_wr = 0, hold_wr = 0, baud_tick = 0, rx_en = 0, ck_in = 0;
  logic [7:0] ctl_wdata = 0, hold_wdata = 0;
  logic [7:0] ctl_rdata;
  logic hold_empty, dout, dout_oe, ck_out, ck_oe;

  always #4 clk = ~clk;

  usart_tx_engine #(.HI_DIV(HI), .LO_DIV(LO), .SYNC_STAGES(SS)) u0 (.*);

  int vectors = 0, errors = 0, cycles = 0;
  string phase = "R1";

  // reference model state
  bit m_mast, m_nine, m_en, m_sync, m_hs, m_b9, m_full, m_ck;
  bit [7:0] m_hold;
  int m_cnt;
  bit q[$];
  bit hist[SS+1];

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_mast, m_nine, m_en, m_sync, m_hs, m_b9, m_full, m_ck} = '0;
      m_hold = 0; m_cnt = 0; q.delete();
      foreach (hist[i]) hist[i] = 0;
    end else begin
      bit busy, frz, go, stp, ld, fall;
      fall = hist[SS] && !hist[SS-1];
      busy = q.size() != 0;
      frz  = m_sync && rx_en;
      go   = m_en && !frz;
      stp  = 0;
      if (busy && !frz) begin
        if (!m_sync) begin
          if (baud_tick) begin
            if (m_cnt == (m_hs ? HI : LO) - 1) begin m_cnt = 0; stp = 1; end
            else m_cnt++;
          end
        end else if (m_mast) begin
          if (baud_tick) begin
            if (m_ck) begin m_ck = 0; stp = 1; end else m_ck = 1;
          end
        end else stp = fall;
      end
      if (stp) void'(q.pop_front());
      ld = !busy && m_full && go;
      if (ld) begin
        if (!m_sync) q.push_back(1'b0);
        for (int i = 0; i < 8; i++) q.push_back(m_hold[i]);
        if (m_nine) q.push_back(m_b9);
        if (!m_sync) q.push_back(1'b1);
        m_cnt = 0; m_ck = 0; m_full = 0;
      end
      if (hold_wr) begin m_hold = hold_wdata; m_full = 1; end
      if (ctl_wr) begin
        m_mast = ctl_wdata[7]; m_nine = ctl_wdata[6]; m_en = ctl_wdata[5];
        m_sync = ctl_wdata[4]; m_hs = ctl_wdata[2]; m_b9 = ctl_wdata[0];
      end
      for (int i = SS; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = ck_in;
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s] t=%0t actual=%h expected=%h", req, phase, $time, act, exp);
    end
  endtask

  // every-cycle comparison, away from the active edge
  always @(posedge clk) if (rst_n) begin
    bit e;
    #3;
    e = (q.size() == 0);
    check("R2 ctl_rdata", ctl_rdata, {m_mast, m_nine, m_en, m_sync, 1'b0, m_hs, e, m_b9});
    check("R3 hold_empty", {7'b0, hold_empty}, {7'b0, !m_full});
    check("R4 dout", {7'b0, dout}, {7'b0, e ? 1'b1 : q[0]});
    check("R9 dout_oe", {7'b0, dout_oe}, {7'b0, m_en && !(m_sync && rx_en)});
    check("R7 ck_out", {7'b0, ck_out}, {7'b0, m_ck});
    check("R11 ck_oe", {7'b0, ck_oe}, {7'b0, m_sync && m_mast});
  end

  // baud tick source
  int tick_div = 1, tcnt = 0;
  always @(negedge clk) begin
    tcnt++;
    if (tcnt >= tick_div) begin tcnt = 0; baud_tick = 1; end else baud_tick = 0;
  end

  // external slave clock
  bit slave_run = 0;
  int scnt = 0;
  always @(negedge clk) begin
    if (slave_run) begin
      scnt++;
      if (scnt == 4) begin scnt = 0; ck_in = ~ck_in; end
    end else begin ck_in = 0; scnt = 0; end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; vectors++;
      $display("FAIL watchdog [%s] expired", phase);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctl_wr = 1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 0;
  endtask

  task automatic wr_hold(input logic [7:0] v);
    @(negedge clk); hold_wr = 1; hold_wdata = v;
    @(negedge clk); hold_wr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    @(negedge clk);
    while (q.size() != 0 || m_full) @(negedge clk);
    idle(3);
  endtask

  // measures the low start bit of a frame carrying 8'hFF
  task automatic start_len(string req, int exp);
    int n = 0;
    wr_hold(8'hFF);
    while (dout !== 1'b0) @(posedge clk) #3;
    while (dout === 1'b0) begin n++; @(posedge clk); #3; end
    check(req, 8'(n), 8'(exp));
    drain();
  endtask

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #3;
    // R1 reset values
    check("R1 ctl_rdata", ctl_rdata, 8'h02);
    check("R1 hold_empty", {7'b0, hold_empty}, 8'h01);
    check("R1 dout", {7'b0, dout}, 8'h01);
    check("R1 ck_oe/ck_out", {6'b0, ck_oe, ck_out}, 8'h00);

    phase = "R2"; // all writable fields, bit 3 and bit 1 not writable
    wr_ctl(8'hFF); @(posedge clk); #3; check("R2 readback", ctl_rdata, 8'hF7);
    wr_ctl(8'h08); @(posedge clk); #3; check("R2 readback", ctl_rdata, 8'h02);

    phase = "R12"; // transmit disabled: byte held
    wr_hold(8'hA5); idle(20);
    check("R12 hold stays full", {7'b0, hold_empty}, 8'h00);
    check("R12 line idle", {7'b0, dout}, 8'h01);

    phase = "R4"; // async fast, loads the held byte, then back to back
    wr_ctl(8'h24); wr_hold(8'h3C); drain();

    phase = "R6";
    start_len("R6 fast start bit", HI);
    wr_ctl(8'h20);
    start_len("R6 slow start bit", LO);
    tick_div = 3; wr_hold(8'h96); drain(); tick_div = 1;

    phase = "R5"; // nine-bit frames, ninth bit 1 then 0
    wr_ctl(8'h65); wr_hold(8'h81); drain();
    wr_ctl(8'h64); wr_hold(8'h7E); drain();

    phase = "R11"; // master select in async mode ignored
    wr_ctl(8'hA4); wr_hold(8'h55); drain();

    phase = "R7"; // sync master, 8 and 9 bits, fast bit ignored
    tick_div = 2;
    wr_ctl(8'hB0); wr_hold(8'hC3); wr_hold(8'h18); drain();
    wr_ctl(8'hF5); wr_hold(8'h5A); drain();

    phase = "R9"; // receive enable overrides transmit
    wr_ctl(8'hB0);
    @(negedge clk); rx_en = 1;
    wr_hold(8'hE7); idle(30);
    check("R9 no load", {7'b0, hold_empty}, 8'h00);
    @(negedge clk); rx_en = 0; idle(6);
    @(negedge clk); rx_en = 1; idle(20);
    @(negedge clk); rx_en = 0; drain();

    phase = "R8"; // sync slave on external clock
    wr_ctl(8'h30);
    slave_run = 1;
    wr_hold(8'h69); drain();
    wr_ctl(8'h70); wr_hold(8'hF0); drain();
    slave_run = 0;

    phase = "R10";
    wr_ctl(8'h24); wr_hold(8'h00); drain();
    @(posedge clk); #3;
    check("R10 status back to empty", {7'b0, ctl_rdata[1]}, 8'h01);

    idle(5);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule